// File: doc/BRIEF.md
# IPv6-in-IPv4 Tunnel Encapsulator

The block receives IPv6 packets as a byte stream, with a marker on the final byte of each packet. It keeps every packet in an internal byte FIFO until the whole packet is there. It then asks a subnet table for a decision, and the table answers after a variable number of cycles. If the packet's IPv6 destination falls inside a tunnel subnet, the packet goes out behind a freshly built 20-byte IPv4 header. That header carries the tunnel endpoint addresses stored with the matching entry. If no subnet matches, the packet goes out byte for byte unchanged.

The subnet table is loaded at run time through a configuration write port. Each entry holds:
- an enable bit,
- a 128-bit prefix,
- a prefix length,
- a local IPv4 address,
- a remote IPv4 address.

Packets leave strictly in arrival order. Both stream edges use valid/ready flow control. A packet may be at most one FIFO depth long and at least 40 bytes long.

Top module: `tunnel_encap`

## Requirements
- R1: Output of a packet starts only after the last byte of that packet has been accepted at the input.
- R2: The lookup key is packet bytes 24..39 (first byte most significant). The first entry, counting from index 0, that is enabled and whose top plen bits equal the key's top plen bits supplies the decision. While the lookup is outstanding, no output is presented.
- R3: On a hit, 20 header bytes precede the unchanged packet:
  - byte 0 is 0x45;
  - bytes 2..3 hold the length N+20, big-endian;
  - byte 8 is the TTL parameter (default 64);
  - byte 9 is 41;
  - bytes 12..15 hold the entry's local address and bytes 16..19 its remote address;
  - bytes 1, 4, 5, 6 and 7 are zero, so the don't-fragment flag is clear.
- R4: Header bytes 10..11 hold the checksum. The ones'-complement sum of all ten 16-bit header words, checksum included, is 0xFFFF.
- R5: On a miss, the N input bytes leave unchanged, with no header.
- R6: A disabled entry never matches. An enabled entry with prefix length 0 matches every destination.
- R7: A configuration write replaces an entry at run time, and later packets use the new contents.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold. out_last is high only on the final byte of an output packet.
- R9: Packets leave in arrival order. out_valid is low in the cycle after a final byte is taken.
- R10: When the FIFO holds DEPTH bytes, in_ready is low. Every accepted byte eventually leaves, and none is dropped.
- R11: After reset, out_valid is low, in_ready is high and every table entry is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input packet byte |
| in_last | input | 1 | Final byte of the input packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the output packet |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IW | Entry index to write |
| cfg_valid | input | 1 | Enable bit for the written entry |
| cfg_prefix | input | 128 | IPv6 prefix |
| cfg_plen | input | 8 | Prefix length, 0..128 |
| cfg_local | input | 32 | Local tunnel endpoint IPv4 address |
| cfg_remote | input | 32 | Remote tunnel endpoint IPv4 address |

## Verification
The hardest situation to reach from the ports is a completely full FIFO, with a second packet stopped in the middle. The bench holds out_ready low, streams a whole packet and then starts a second one in the background. It counts accepted bytes until in_ready drops at exactly the FIFO depth. Only then does it release the output and check that both packets arrive intact.

Priority between overlapping subnets is reached by loading a long and a short prefix that both cover one destination. The catch-all case is reached by enabling a zero-length entry in the last slot.

// File: rtl/tunnel_encap_pkg.sv
package tunnel_encap_pkg;

    localparam int DST_FIRST  = 24;
    localparam int DST_AFTER  = 40;
    localparam int V4_HDR_LEN = 20;
    localparam logic [7:0] PROTO_V6 = 8'd41;

    typedef struct packed {
        logic         vld;
        logic [127:0] pfx;
        logic [7:0]   plen;
        logic [31:0]  loc;
        logic [31:0]  rem;
    } tun_entry_t;

    typedef struct packed {
        logic [127:0] dst;
        logic [15:0]  len;
    } pkt_desc_t;

    typedef enum logic [2:0] {RD_IDLE, RD_REQ, RD_WAIT, RD_HDR, RD_BODY} rd_state_t;

    function automatic logic [127:0] prefix_mask(input logic [7:0] plen);
        logic [127:0] m;
        for (int i = 0; i < 128; i++) m[127-i] = (i < int'(plen));
        return m;
    endfunction

    function automatic logic [15:0] ip4_csum(input logic [15:0] tot, input logic [7:0] ttl,
                                             input logic [31:0] src, input logic [31:0] dst);
        logic [19:0] s;
        s = 20'h04500 + {4'd0, tot} + {4'd0, ttl, PROTO_V6}
          + {4'd0, src[31:16]} + {4'd0, src[15:0]}
          + {4'd0, dst[31:16]} + {4'd0, dst[15:0]};
        s = {4'd0, s[15:0]} + {16'd0, s[19:16]};
        s = {4'd0, s[15:0]} + {16'd0, s[19:16]};
        return ~s[15:0];
    endfunction

    function automatic logic [7:0] ip4_hdr_byte(input logic [4:0] idx, input logic [15:0] tot,
                                                 input logic [15:0] csum, input logic [7:0] ttl,
                                                 input logic [31:0] src, input logic [31:0] dst);
        case (idx)
            5'd0:    return 8'h45;
            5'd2:    return tot[15:8];
            5'd3:    return tot[7:0];
            5'd8:    return ttl;
            5'd9:    return PROTO_V6;
            5'd10:   return csum[15:8];
            5'd11:   return csum[7:0];
            5'd12:   return src[31:24];
            5'd13:   return src[23:16];
            5'd14:   return src[15:8];
            5'd15:   return src[7:0];
            5'd16:   return dst[31:24];
            5'd17:   return dst[23:16];
            5'd18:   return dst[15:8];
            5'd19:   return dst[7:0];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/tunnel_fifo.sv
module tunnel_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/tunnel_lookup.sv
module tunnel_lookup
    import tunnel_encap_pkg::*;
#(
    parameter int NENT = 4,
    localparam int IW  = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  tun_entry_t    cfg_entry,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [127:0]  req_dst,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic [31:0]   rsp_loc,
    output logic [31:0]   rsp_rem
);
    tun_entry_t    tbl [NENT];
    logic          busy;
    logic [IW-1:0] idx;
    logic [127:0]  key;
    tun_entry_t    cur;
    logic          hit_now;

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                                tbl[g] <= '0;
            else if (cfg_we && cfg_idx == IW'(g))   tbl[g] <= cfg_entry;
        end
    end

    assign req_ready = !busy;
    assign cur       = tbl[idx];
    assign hit_now   = cur.vld && (((key ^ cur.pfx) & prefix_mask(cur.plen)) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            idx       <= '0;
            key       <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_loc   <= '0;
            rsp_rem   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (req_valid && !busy) begin
                busy <= 1'b1;
                idx  <= '0;
                key  <= req_dst;
            end else if (busy) begin
                if (hit_now || idx == IW'(NENT-1)) begin
                    busy      <= 1'b0;
                    rsp_valid <= 1'b1;
                    rsp_hit   <= hit_now;
                    rsp_loc   <= cur.loc;
                    rsp_rem   <= cur.rem;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tunnel_emit.sv
module tunnel_emit
    import tunnel_encap_pkg::*;
#(
    parameter logic [7:0] TTL = 8'd64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         desc_empty,
    input  pkt_desc_t    desc_rd,
    output logic         desc_pop,
    output logic         lkp_req_valid,
    input  logic         lkp_req_ready,
    output logic [127:0] lkp_req_dst,
    input  logic         lkp_rsp_valid,
    input  logic         lkp_rsp_hit,
    input  logic [31:0]  lkp_rsp_loc,
    input  logic [31:0]  lkp_rsp_rem,
    input  logic [8:0]   dat_rd,
    input  logic         dat_empty,
    output logic         dat_pop,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [7:0]   out_data,
    output logic         out_last
);
    rd_state_t    st;
    logic [127:0] dst_q;
    logic [15:0]  len_q, tot;
    logic [31:0]  loc_q, rem_q;
    logic [15:0]  csum_q;
    logic [4:0]   hidx;

    assign tot           = len_q + 16'(V4_HDR_LEN);
    assign desc_pop      = (st == RD_IDLE) && !desc_empty;
    assign lkp_req_valid = (st == RD_REQ);
    assign lkp_req_dst   = dst_q;
    assign out_valid     = (st == RD_HDR) || ((st == RD_BODY) && !dat_empty);
    assign out_data      = (st == RD_HDR) ? ip4_hdr_byte(hidx, tot, csum_q, TTL, loc_q, rem_q)
                                          : dat_rd[7:0];
    assign out_last      = (st == RD_BODY) && dat_rd[8];
    assign dat_pop       = (st == RD_BODY) && !dat_empty && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RD_IDLE;
            dst_q  <= '0;
            len_q  <= '0;
            loc_q  <= '0;
            rem_q  <= '0;
            csum_q <= '0;
            hidx   <= '0;
        end else begin
            case (st)
                RD_IDLE: if (!desc_empty) begin
                    dst_q <= desc_rd.dst;
                    len_q <= desc_rd.len;
                    st    <= RD_REQ;
                end
                RD_REQ: if (lkp_req_ready) st <= RD_WAIT;
                RD_WAIT: if (lkp_rsp_valid) begin
                    loc_q  <= lkp_rsp_loc;
                    rem_q  <= lkp_rsp_rem;
                    csum_q <= ip4_csum(tot, TTL, lkp_rsp_loc, lkp_rsp_rem);
                    hidx   <= '0;
                    st     <= lkp_rsp_hit ? RD_HDR : RD_BODY;
                end
                RD_HDR: if (out_ready) begin
                    hidx <= hidx + 1'b1;
                    if (hidx == 5'(V4_HDR_LEN-1)) st <= RD_BODY;
                end
                RD_BODY: if (dat_pop && dat_rd[8]) st <= RD_IDLE;
                default: st <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tunnel_encap.sv
module tunnel_encap
    import tunnel_encap_pkg::*;
#(
    parameter int         DEPTH      = 256,
    parameter int         DESC_DEPTH = 4,
    parameter int         NENT       = 4,
    parameter logic [7:0] TTL        = 8'd64,
    localparam int        IW         = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_last,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic          cfg_valid,
    input  logic [127:0]  cfg_prefix,
    input  logic [7:0]    cfg_plen,
    input  logic [31:0]   cfg_local,
    input  logic [31:0]   cfg_remote
);
    localparam int DW = $bits(pkt_desc_t);

    logic         acc, dat_full, dat_empty, dat_pop, desc_full, desc_empty, desc_pop;
    logic [8:0]   dat_rd;
    logic [DW-1:0] desc_rd_v;
    pkt_desc_t    desc_wr;
    logic [15:0]  wr_cnt;
    logic [127:0] dst_acc, dst_nx;
    logic         lkp_req_valid, lkp_req_ready, lkp_rsp_valid, lkp_rsp_hit;
    logic [127:0] lkp_req_dst;
    logic [31:0]  lkp_rsp_loc, lkp_rsp_rem;
    tun_entry_t   cfg_entry;

    assign in_ready = !dat_full && !desc_full;
    assign acc      = in_valid && in_ready;
    assign dst_nx   = (wr_cnt >= 16'(DST_FIRST) && wr_cnt < 16'(DST_AFTER))
                    ? {dst_acc[119:0], in_data} : dst_acc;
    assign desc_wr  = '{dst: dst_nx, len: wr_cnt + 16'd1};
    assign cfg_entry = '{vld: cfg_valid, pfx: cfg_prefix, plen: cfg_plen,
                         loc: cfg_local, rem: cfg_remote};

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt  <= '0;
            dst_acc <= '0;
        end else if (acc) begin
            dst_acc <= dst_nx;
            wr_cnt  <= in_last ? 16'd0 : wr_cnt + 16'd1;
        end
    end

    tunnel_fifo #(.W(9), .DEPTH(DEPTH)) u_dat (
        .clk(clk), .rst(rst), .push(acc), .wr_data({in_last, in_data}),
        .pop(dat_pop), .rd_data(dat_rd), .full(dat_full), .empty(dat_empty)
    );

    tunnel_fifo #(.W(DW), .DEPTH(DESC_DEPTH)) u_desc (
        .clk(clk), .rst(rst), .push(acc && in_last), .wr_data(desc_wr),
        .pop(desc_pop), .rd_data(desc_rd_v), .full(desc_full), .empty(desc_empty)
    );

    tunnel_lookup #(.NENT(NENT)) u_lkp (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_entry(cfg_entry),
        .req_valid(lkp_req_valid), .req_ready(lkp_req_ready), .req_dst(lkp_req_dst),
        .rsp_valid(lkp_rsp_valid), .rsp_hit(lkp_rsp_hit),
        .rsp_loc(lkp_rsp_loc), .rsp_rem(lkp_rsp_rem)
    );

    tunnel_emit #(.TTL(TTL)) u_emit (
        .clk(clk), .rst(rst), .desc_empty(desc_empty), .desc_rd(pkt_desc_t'(desc_rd_v)),
        .desc_pop(desc_pop), .lkp_req_valid(lkp_req_valid), .lkp_req_ready(lkp_req_ready),
        .lkp_req_dst(lkp_req_dst), .lkp_rsp_valid(lkp_rsp_valid), .lkp_rsp_hit(lkp_rsp_hit),
        .lkp_rsp_loc(lkp_rsp_loc), .lkp_rsp_rem(lkp_rsp_rem), .dat_rd(dat_rd),
        .dat_empty(dat_empty), .dat_pop(dat_pop), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: rtl/tunnel_encap_chk.sv
module tunnel_encap_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       lkp_req_valid,
    input logic       lkp_req_ready,
    input logic       lkp_rsp_valid,
    input logic       dat_full
);
    a_r10_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dat_full) |-> !in_ready);

    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (lkp_req_valid && !lkp_req_ready) |=> lkp_req_valid);

    a_r2_quiet_lookup: assert property (@(posedge clk) disable iff (rst)
        (lkp_req_valid || lkp_rsp_valid) |-> !out_valid);

    a_r9_gap_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

bind tunnel_encap tunnel_encap_chk u_chk (.*);

// File: tb/tb_tunnel_encap.sv
module tb_tunnel_encap;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam logic [7:0] TTLV = 8'd64;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_last = 0, out_ready = 1;
    logic [7:0] in_data = 0;
    logic in_ready, out_valid, out_last;
    logic [7:0] out_data;
    logic cfg_we = 0, cfg_valid = 0;
    logic [1:0] cfg_idx = 0;
    logic [127:0] cfg_prefix = 0;
    logic [7:0] cfg_plen = 0;
    logic [31:0] cfg_local = 0, cfg_remote = 0;

    int ntests = 0, nfail = 0, in_acc = 0, nlast = 0;
    logic [7:0] pkt[$], expq[$], rx[$];

    localparam logic [127:0] DST_A = 128'h2001_0db8_0001_0000_0000_0000_0000_0005;
    localparam logic [127:0] DST_B = 128'h2001_0db8_00aa_0000_0000_0000_0000_0009;
    localparam logic [127:0] DST_M = 128'h2002_0000_0000_0000_0000_0000_0000_0001;

    tunnel_encap #(.DEPTH(DEPTH), .NENT(4), .TTL(TTLV)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        #1;
        if (out_valid && out_ready) begin
            rx.push_back(out_data);
            if (out_last) nlast++;
        end
        if (in_valid && in_ready) in_acc++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", ntests + 1, nfail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic build_pkt(input int n, input logic [127:0] dst, input logic [7:0] seed);
        pkt.delete();
        for (int i = 0; i < n; i++) begin
            if (i == 0) pkt.push_back(8'h60);
            else if (i >= 24 && i < 40) pkt.push_back(dst[8*(39-i) +: 8]);
            else pkt.push_back(8'(seed + 8'(i * 7)));
        end
    endtask

    function automatic logic [15:0] ref_csum(input int n, input logic [31:0] s, input logic [31:0] d);
        logic [31:0] sum;
        sum = 32'h4500 + 32'(n + 20) + {16'd0, TTLV, 8'd41}
            + {16'd0, s[31:16]} + {16'd0, s[15:0]} + {16'd0, d[31:16]} + {16'd0, d[15:0]};
        while (sum[31:16] != 0) sum = {16'd0, sum[15:0]} + {16'd0, sum[31:16]};
        return ~sum[15:0];
    endfunction

    task automatic add_exp(input bit hit, input logic [31:0] s, input logic [31:0] d);
        if (hit) begin
            logic [15:0] tot, cs;
            tot = 16'(pkt.size() + 20);
            cs  = ref_csum(pkt.size(), s, d);
            expq.push_back(8'h45); expq.push_back(8'h00);
            expq.push_back(tot[15:8]); expq.push_back(tot[7:0]);
            repeat (4) expq.push_back(8'h00);
            expq.push_back(TTLV); expq.push_back(8'd41);
            expq.push_back(cs[15:8]); expq.push_back(cs[7:0]);
            for (int k = 3; k >= 0; k--) expq.push_back(s[8*k +: 8]);
            for (int k = 3; k >= 0; k--) expq.push_back(d[8*k +: 8]);
        end
        foreach (pkt[i]) expq.push_back(pkt[i]);
    endtask

    task automatic send_pkt();
        for (int i = 0; i < pkt.size(); i++) begin
            in_valid = 1; in_data = pkt[i]; in_last = (i == pkt.size() - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 0; in_last = 0;
    endtask

    task automatic cfg_write(input int idx, input bit v, input logic [127:0] p, input int pl,
                             input logic [31:0] s, input logic [31:0] d);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_valid = v; cfg_prefix = p; cfg_plen = 8'(pl);
        cfg_local = s; cfg_remote = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic check_rx(input string req, input int npk);
        int t = 0, bad = -1;
        while ((rx.size() < expq.size() || nlast < npk) && t < 5000) begin @(negedge clk); t++; end
        repeat (5) @(negedge clk);
        chk(rx.size() == expq.size(), req, "byte count", rx.size(), expq.size());
        chk(nlast == npk, req, "packet count", nlast, npk);
        for (int i = 0; i < expq.size() && i < rx.size(); i++)
            if (bad < 0 && rx[i] !== expq[i]) bad = i;
        if (bad >= 0) chk(0, req, $sformatf("byte %0d", bad), rx[bad], expq[bad]);
        else chk(1, req, "bytes", 0, 0);
    endtask

    task automatic clear_rx();
        rx.delete(); expq.delete(); nlast = 0;
    endtask

    task automatic check_hdr_sum(input string req);
        logic [31:0] sum = 0;
        for (int i = 0; i < 20; i += 2) sum += {16'd0, rx[i], rx[i+1]};
        while (sum[31:16] != 0) sum = {16'd0, sum[15:0]} + {16'd0, sum[31:16]};
        chk(sum[15:0] == 16'hFFFF, req, "header word sum", sum, 32'hFFFF);
    endtask

    task automatic t_reset();
        chk(out_valid == 0, "R11", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1, "R11", "in_ready after reset", in_ready, 1);
        build_pkt(48, DST_A, 8'h10); add_exp(0, 0, 0); send_pkt();
        check_rx("R11 empty table passes packet", 1); clear_rx();
    endtask

    task automatic t_whole_first();
        bit early = 0;
        build_pkt(45, DST_M, 8'h20); add_exp(0, 0, 0);
        for (int i = 0; i < pkt.size(); i++) begin
            in_valid = 1; in_data = pkt[i]; in_last = (i == pkt.size() - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 0;
            repeat (2) begin if (out_valid) early = 1; @(negedge clk); end
        end
        in_last = 0;
        chk(!early, "R1", "output before last byte", early, 0);
        check_rx("R1", 1); clear_rx();
    endtask

    task automatic t_hit_basic();
        cfg_write(2, 1, 128'h2001_0db8 << 96, 32, 32'hC0A80001, 32'hC0A80002);
        build_pkt(57, DST_A, 8'h30); add_exp(1, 32'hC0A80001, 32'hC0A80002); send_pkt();
        check_rx("R3", 1);
        check_hdr_sum("R4");
        clear_rx();
        build_pkt(40, DST_M, 8'h31); add_exp(0, 0, 0); send_pkt();
        check_rx("R5 miss unchanged", 1); clear_rx();
    endtask

    task automatic t_priority();
        cfg_write(0, 1, 128'h2001_0db8_00aa << 80, 48, 32'h0A000001, 32'h0A000002);
        build_pkt(50, DST_B, 8'h40); add_exp(1, 32'h0A000001, 32'h0A000002); send_pkt();
        check_rx("R2 lowest index wins", 1); clear_rx();
        build_pkt(50, DST_A, 8'h41); add_exp(1, 32'hC0A80001, 32'hC0A80002); send_pkt();
        check_rx("R2 longer prefix skipped", 1); clear_rx();
    endtask

    task automatic t_catch_all();
        cfg_write(3, 0, 0, 0, 32'hAC100001, 32'hAC100002);
        build_pkt(44, DST_M, 8'h50); add_exp(0, 0, 0); send_pkt();
        check_rx("R6 disabled entry", 1); clear_rx();
        cfg_write(3, 1, 0, 0, 32'hAC100001, 32'hAC100002);
        build_pkt(44, DST_M, 8'h51); add_exp(1, 32'hAC100001, 32'hAC100002); send_pkt();
        check_rx("R6 zero-length prefix", 1); clear_rx();
        cfg_write(3, 0, 0, 0, 0, 0);
    endtask

    task automatic t_rewrite();
        cfg_write(0, 1, 128'h2001_0db8_00aa << 80, 48, 32'h0B000001, 32'h0B000002);
        build_pkt(64, DST_B, 8'h60); add_exp(1, 32'h0B000001, 32'h0B000002); send_pkt();
        check_rx("R7 rewritten entry", 1); clear_rx();
    endtask

    task automatic t_stall();
        logic [7:0] d0;
        int t = 0;
        out_ready = 0;
        build_pkt(41, DST_A, 8'h70); add_exp(1, 32'hC0A80001, 32'hC0A80002); send_pkt();
        while (!out_valid && t < 500) begin @(negedge clk); t++; end
        d0 = out_data;
        repeat (5) @(negedge clk);
        chk(out_valid && out_data == d0, "R8", "held byte", {out_valid, out_data}, {1'b1, d0});
        chk(d0 == 8'h45, "R8", "first held byte", d0, 8'h45);
        out_ready = 1;
        check_rx("R8", 1); clear_rx();
    endtask

    task automatic t_order();
        build_pkt(46, DST_A, 8'h80); add_exp(1, 32'hC0A80001, 32'hC0A80002); send_pkt();
        build_pkt(40, DST_M, 8'h81); add_exp(0, 0, 0); send_pkt();
        build_pkt(52, DST_B, 8'h82); add_exp(1, 32'h0B000001, 32'h0B000002); send_pkt();
        check_rx("R9 order", 3); clear_rx();
    endtask

    task automatic t_backpressure();
        int base;
        out_ready = 0;
        base = in_acc;
        build_pkt(40, DST_M, 8'h90); add_exp(0, 0, 0); send_pkt();
        build_pkt(48, DST_M, 8'h91); add_exp(0, 0, 0);
        fork send_pkt(); join_none
        repeat (60) @(negedge clk);
        chk(in_acc - base == DEPTH, "R10", "bytes taken when full", in_acc - base, DEPTH);
        chk(in_ready == 0, "R10", "in_ready when full", in_ready, 0);
        out_ready = 1;
        wait fork;
        check_rx("R10 nothing dropped", 2); clear_rx();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_whole_first();
        t_hit_basic();
        t_priority();
        t_catch_all();
        t_rewrite();
        t_stall();
        t_order();
        t_backpressure();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule